// File: doc/BRIEF.md
# Edge-Triggered Input Capture Timer

This block measures the time between selected transitions on a single event pin. An 8-bit up-counter advances once every `PRESCALE` clock cycles. When an enabled transition arrives, the counter value is latched into a capture holding register, the counter restarts from zero, and a capture interrupt request and a capture status flag are raised. If another transition arrives, or the counter wraps, while the status flag is still set, a capture error flag is raised. This tells software that a measurement was missed.

Software drives the block through a small register port with a combinational read path. It can select which transitions count, enable capture mode, read the captured value as two 4-bit nibbles, and clear each flag by writing zero to its bit. Mode-register writes are rate limited. A write that lands one cycle after an accepted mode write is dropped.

Top module: `edge_capture_timer`

## Requirements
- R1: Control register at address 0, bits [1:0], selects the trigger: 00 none, 01 falling only, 10 rising only, 11 both. Bit 2 enables capture mode. A read of address 0 returns {0, enable, select}. Transitions that are not selected, or that occur while capture is disabled, change no flag and no captured value.
- R2: On a capture, the counter value from the cycle before the capture edge is stored in the holding register. Address 1 reads its bits [3:0] and address 2 reads bits [7:4]. Reads do not change it.
- R3: A capture sets the status flag (address 3, bit 0) and the interrupt request flag (address 4, bit 0, also driven on `irq_req`).
- R4: A pin change that is set up before clock edge n is captured at edge n+2. The counter restarts at zero with its prescaler phase reset, then counts up once per `PRESCALE` cycles. A capture k edges after the reference edge therefore holds floor((k-1)/PRESCALE) mod 256.
- R5: A capture that occurs while the status flag is set also sets the error flag (address 3, bit 1).
- R6: A counter wrap (255 to 0) while the status flag is set sets the error flag. A wrap while the status flag is clear does not.
- R7: Each flag clears only at reset, or when software writes 0 to its bit (status: address 3 bit 0; error: address 3 bit 1; interrupt: address 4 bit 0). Writing 1 has no effect.
- R8: If a capture and a software clear of the same flag occur in one cycle, the flag ends up set.
- R9: An accepted control write that turns capture mode on clears the counter and the prescaler.
- R10: A control write is accepted only if no control write was accepted in the previous cycle. A dropped write leaves the control register unchanged.
- R11: After reset, the control register, captured value, counter and all flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_in | input | 1 | Asynchronous event pin |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W (3) | Register address |
| bus_wdata | input | DATA_W (4) | Register write data |
| bus_rdata | output | DATA_W (4) | Register read data, combinational from `bus_addr` |
| irq_req | output | 1 | Capture interrupt request flag |

## Verification
A change on the event pin reaches the capture register and the flags at the third rising clock edge after it is driven. Register writes take effect at the edge that samples them, and reads return data in the same cycle. The bench drives every input just after a falling edge. It counts rising edges from the reference edge (the capture, or the write that enabled capture mode) to the capture edge, and forms the expected count as floor((k-1)/PRESCALE). It then reads the results at the falling edge that follows the edge where they are due. For the set-over-clear case, the bench places the clear write on exactly the capture edge.

// File: rtl/ict_pkg.sv
package ict_pkg;

  typedef enum logic [1:0] {
    TRIG_NONE = 2'b00,
    TRIG_FALL = 2'b01,
    TRIG_RISE = 2'b10,
    TRIG_BOTH = 2'b11
  } trig_sel_e;

  localparam logic [2:0] ADR_CTRL     = 3'd0;
  localparam logic [2:0] ADR_CAP_BASE = 3'd1;

  // bit 1 of the select arms rising transitions, bit 0 arms falling ones
  function automatic logic trig_match(trig_sel_e sel, logic prev, logic cur);
    trig_match = (sel[1] && !prev && cur) || (sel[0] && prev && !cur);
  endfunction

  function automatic logic flag_clear_req(logic we, logic addr_hit, logic bit_val);
    flag_clear_req = we && addr_hit && !bit_val;
  endfunction

endpackage

// File: rtl/ict_edge_detect.sv
module ict_edge_detect
  import ict_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pin_in,
  input  trig_sel_e sel,
  output logic      hit
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_in};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign hit = trig_match(sel, prev_q, sync_q[SYNC_STAGES-1]);

endmodule

// File: rtl/ict_counter.sv
module ict_counter #(
  parameter int CNT_W    = 8,
  parameter int PRESCALE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clear,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);

  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic             tick;

  assign tick  = (pre_q == PRE_LAST);
  assign wrap  = run && !clear && tick && (cnt_q == '1);
  assign count = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (clear) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (run) begin
      if (tick) begin
        pre_q <= '0;
        cnt_q <= cnt_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/ict_flag.sv
module ict_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);

  // set dominates clear so that a capture is never lost
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= 1'b0;
    else if (set_i) q <= 1'b1;
    else if (clr_i) q <= 1'b0;
  end

endmodule

// File: rtl/edge_capture_timer.sv
module edge_capture_timer
  import ict_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int DATA_W      = 4,
  parameter int ADDR_W      = 3,
  parameter int PRESCALE    = 4,
  parameter int SYNC_STAGES = 2,
  parameter int GUARD_CYC   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_in,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_req
);

  localparam int NUM_NIB = CNT_W / DATA_W;
  localparam int GW      = $clog2(GUARD_CYC + 1);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(ADR_CTRL);
  localparam logic [ADDR_W-1:0] A_BASE  = ADDR_W'(ADR_CAP_BASE);
  localparam logic [ADDR_W-1:0] A_FLAGS = ADDR_W'(ADR_CAP_BASE + NUM_NIB);
  localparam logic [ADDR_W-1:0] A_IRQ   = ADDR_W'(ADR_CAP_BASE + NUM_NIB + 1);

  // named internal events
  logic             mode_wr, mode_acc, en_rise;
  logic             edge_hit, cap_evt, ovf_evt, cnt_clear;
  logic             sts_clr, err_clr, irq_clr, err_set;
  logic             sts_q, err_q;
  trig_sel_e        trig_q;
  logic             cap_en_q;
  logic [GW-1:0]    guard_q;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] cap_q;
  logic             unused_wbits;

  assign unused_wbits = ^bus_wdata[DATA_W-1:3];

  // control register with write-rate guard
  assign mode_wr  = bus_we && (bus_addr == A_CTRL);
  assign mode_acc = mode_wr && (guard_q == '0);
  assign en_rise  = mode_acc && bus_wdata[2] && !cap_en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q   <= TRIG_NONE;
      cap_en_q <= 1'b0;
      guard_q  <= '0;
    end else begin
      if (mode_acc) begin
        trig_q   <= trig_sel_e'(bus_wdata[1:0]);
        cap_en_q <= bus_wdata[2];
        guard_q  <= GW'(GUARD_CYC - 1);
      end else if (guard_q != '0) begin
        guard_q  <= guard_q - 1'b1;
      end
    end
  end

  ict_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_in (evt_in),
    .sel    (trig_q),
    .hit    (edge_hit)
  );

  assign cap_evt   = cap_en_q && edge_hit;
  assign cnt_clear = en_rise || cap_evt;

  ict_counter #(.CNT_W(CNT_W), .PRESCALE(PRESCALE)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (cap_en_q),
    .clear (cnt_clear),
    .count (count),
    .wrap  (ovf_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cap_q <= '0;
    else if (cap_evt) cap_q <= count;
  end

  // flags
  assign sts_clr = flag_clear_req(bus_we, bus_addr == A_FLAGS, bus_wdata[0]);
  assign err_clr = flag_clear_req(bus_we, bus_addr == A_FLAGS, bus_wdata[1]);
  assign irq_clr = flag_clear_req(bus_we, bus_addr == A_IRQ,   bus_wdata[0]);
  assign err_set = sts_q && (cap_evt || ovf_evt);

  ict_flag u_sts (.clk(clk), .rst_n(rst_n), .set_i(cap_evt), .clr_i(sts_clr), .q(sts_q));
  ict_flag u_err (.clk(clk), .rst_n(rst_n), .set_i(err_set), .clr_i(err_clr), .q(err_q));
  ict_flag u_irq (.clk(clk), .rst_n(rst_n), .set_i(cap_evt), .clr_i(irq_clr), .q(irq_req));

  // read path
  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_CTRL)
      bus_rdata = DATA_W'({cap_en_q, trig_q});
    else if (bus_addr == A_FLAGS)
      bus_rdata = DATA_W'({err_q, sts_q});
    else if (bus_addr == A_IRQ)
      bus_rdata = DATA_W'(irq_req);
    for (int i = 0; i < NUM_NIB; i++) begin
      if (bus_addr == ADDR_W'(A_BASE + i))
        bus_rdata = cap_q[i*DATA_W +: DATA_W];
    end
  end

endmodule

// File: rtl/ict_checker.sv
module ict_checker #(
  parameter int CNT_W  = 8,
  parameter int DATA_W = 4,
  parameter int ADDR_W = 3,
  parameter logic [ADDR_W-1:0] FLAGS_ADR = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              cap_evt,
  input logic              ovf_evt,
  input logic              mode_acc,
  input logic              cap_en_q,
  input logic [CNT_W-1:0]  count,
  input logic [CNT_W-1:0]  cap_q,
  input logic              sts_q,
  input logic              err_q,
  input logic              irq_req
);

  logic sts_wr0;
  assign sts_wr0 = bus_we && (bus_addr == FLAGS_ADR) && !bus_wdata[0];

  assert_capture_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (cap_q == $past(count)));

  assert_capture_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (sts_q && irq_req));

  assert_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (count == '0));

  assert_second_edge_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt && sts_q) |=> err_q);

  assert_overflow_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && sts_q) |=> err_q);

  assert_status_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q && !sts_wr0) |=> sts_q);

  assert_set_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt && sts_wr0) |=> sts_q);

  assert_enable_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cap_en_q) |-> (count == '0));

  assert_mode_guard_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mode_acc |=> !mode_acc);

endmodule

bind edge_capture_timer ict_checker #(
  .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .FLAGS_ADR(A_FLAGS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .cap_evt(cap_evt), .ovf_evt(ovf_evt),
  .mode_acc(mode_acc), .cap_en_q(cap_en_q), .count(count), .cap_q(cap_q),
  .sts_q(sts_q), .err_q(err_q), .irq_req(irq_req)
);

// File: tb/sim_edge_capture_timer.sv
module sim_edge_capture_timer;

  localparam int CLK_P = 10;
  localparam int PRE   = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       evt = 1'b0;
  logic       we = 1'b0;
  logic [2:0] addr = '0;
  logic [3:0] wdata = '0;
  logic [3:0] rdata;
  logic       irq;

  int vectors = 0;
  int fails = 0;

  always #(CLK_P/2) clk = ~clk;

  edge_capture_timer u0 (
    .clk(clk), .rst_n(rst_n), .evt_in(evt), .bus_we(we),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq_req(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic bus_write(input int a, input int d);
    we = 1'b1; addr = 3'(a); wdata = 4'(d);
    @(posedge clk); @(negedge clk);
    we = 1'b0;
  endtask

  task automatic bus_read(input int a, output int d);
    addr = 3'(a);
    #1 d = int'(rdata);
  endtask

  // disable, set the pin level, then enable with the given trigger select
  task automatic arm(input int sel, input logic lvl);
    idle();
    bus_write(0, sel);
    evt = lvl;
    repeat (4) idle();
    bus_write(0, sel | 4);
  endtask

  // toggles the pin w cycles after the reference edge, returns after capture edge
  task automatic capture_after(input int w);
    repeat (w) idle();
    evt = ~evt;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int expect_cap(input int w);
    return ((w + 2) / PRE) % 256;
  endfunction

  task automatic clear_all();
    bus_write(3, 0);
    bus_write(4, 0);
  endtask

  task automatic read_cap(output int v);
    int lo, hi;
    bus_read(1, lo);
    bus_read(2, hi);
    v = hi * 16 + lo;
  endtask

  task automatic t_reset();
    int d;
    bus_read(0, d); check("R11 ctrl", d, 0);
    bus_read(1, d); check("R11 cap lo", d, 0);
    bus_read(2, d); check("R11 cap hi", d, 0);
    bus_read(3, d); check("R11 flags", d, 0);
    check("R11 irq", int'(irq), 0);
  endtask

  task automatic t_chain();
    int d, d2;
    arm(3, 1'b0);
    capture_after(4);
    read_cap(d); check("R2 R4 first interval", d, expect_cap(4));
    bus_read(3, d); check("R3 status set, R5 no error", d, 1);
    check("R3 irq", int'(irq), 1);
    capture_after(80);
    bus_read(1, d); check("R2 low nibble", d, expect_cap(80) % 16);
    bus_read(2, d); check("R2 high nibble", d, expect_cap(80) / 16);
    bus_read(3, d); check("R5 error on edge while status set", d, 3);
    read_cap(d); read_cap(d2); check("R2 read keeps value", d2, d);
  endtask

  task automatic t_clear();
    int d;
    bus_write(3, 3); bus_read(3, d); check("R7 writing ones ignored", d, 3);
    bus_write(4, 1); check("R7 irq write one ignored", int'(irq), 1);
    bus_write(3, 2); bus_read(3, d); check("R7 clear status only", d, 2);
    bus_write(3, 0); bus_read(3, d); check("R7 clear error", d, 0);
    bus_write(4, 0); check("R7 clear irq", int'(irq), 0);
  endtask

  task automatic t_modes();
    int d;
    arm(2, 1'b0);
    capture_after(5);
    bus_read(3, d); check("R1 rising captured", d, 1);
    read_cap(d); check("R1 rising value", d, expect_cap(5));
    clear_all();
    capture_after(5);
    bus_read(3, d); check("R1 falling ignored in rise mode", d, 0);
    check("R1 falling no irq", int'(irq), 0);
    read_cap(d); check("R1 value kept", d, expect_cap(5));
    arm(1, 1'b1);
    capture_after(5);
    bus_read(3, d); check("R1 falling captured", d, 1);
    clear_all();
    capture_after(3);
    bus_read(3, d); check("R1 rising ignored in fall mode", d, 0);
    arm(0, 1'b0);
    capture_after(3);
    capture_after(3);
    bus_read(3, d); check("R1 select none ignores edges", d, 0);
    check("R1 select none no irq", int'(irq), 0);
  endtask

  task automatic t_set_wins();
    int d;
    arm(3, evt);
    repeat (3) idle();
    evt = ~evt;
    @(posedge clk); @(posedge clk); @(negedge clk);
    we = 1'b1; addr = 3'd3; wdata = 4'd0;
    @(posedge clk); @(negedge clk);
    we = 1'b0;
    bus_read(3, d); check("R8 capture beats clear", d, 1);
    check("R8 irq set", int'(irq), 1);
    clear_all();
  endtask

  task automatic t_enable_clear();
    int d;
    arm(3, evt);
    repeat (40) idle();
    bus_write(0, 3);
    idle();
    bus_write(0, 7);
    capture_after(1);
    read_cap(d); check("R9 enable clears counter", d, expect_cap(1));
    clear_all();
  endtask

  task automatic t_guard();
    int d;
    idle();
    bus_write(0, 5);
    bus_write(0, 6);
    bus_read(0, d); check("R10 back-to-back write dropped", d, 5);
    bus_write(0, 7);
    bus_read(0, d); check("R10 write after gap accepted", d, 7);
  endtask

  task automatic t_overflow();
    int d;
    clear_all();
    arm(3, evt);
    capture_after(0);
    read_cap(d); check("R4 immediate capture", d, expect_cap(0));
    bus_write(3, 0);
    repeat (1100) idle();
    bus_read(3, d); check("R6 wrap without status no error", d, 0);
    capture_after(0);
    bus_read(3, d); check("R6 status before wrap", d, 1);
    repeat (1100) idle();
    bus_read(3, d); check("R6 wrap with status sets error", d, 3);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_chain();
    t_clear();
    t_modes();
    t_set_wins();
    t_enable_clear();
    t_guard();
    t_overflow();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule